// File: doc/BRIEF.md
# Power-Management Event Status and SCI Generator

This block keeps the fixed power-management event status and enable bits, plus a small block of general-purpose event bytes, and drives a level-sensitive system control interrupt (SCI) from them. Hardware event inputs set status bits: power button, real-time-clock alarm, global lock release, timer overflow, PCI hotplug and CPU hotplug. Software reads and clears the status bits and programs the enable bits through a byte-wide register bus. The SCI output is high while any enabled status bit in the selected subset is set. It is a registered output.

The same register bus carries an APM command port. One command value turns the SCI enable control bit on and another turns it off. Any command written to this port can also pulse an SMI output, if the SMI-control byte allows it. The timer counter itself lives elsewhere. Only its overflow pulse arrives here.

Top module: `pm_evt_sci`

## Requirements
- R1: After synchronous reset, every register reads 0x00 and `sci`, `smi` and `tmr_armed` are 0.
- R2: A one-cycle pulse on `evt_tmr`, `evt_glk`, `evt_pwr` or `evt_rtc` sets the fixed status bit at position 0, 5, 8 or 10. Bits 7:0 read at address 0 and bits 15:8 read at address 1. All other fixed status bits read 0.
- R3: The fixed status bits and the general-purpose status bytes are write-one-to-clear: a 1 in the written byte clears that bit and a 0 leaves it alone. The fixed enable bits are plain read/write at address 2 (bits 7:0) and address 3 (bits 15:8). Only positions 0, 5, 8 and 10 hold a value; the rest read 0.
- R4: When an event pulse and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R5: `sci` is high when fixed status AND fixed enable has any of bits 0, 5, 8 or 10 set, or when general-purpose status byte 0 AND enable byte 0 has bit 1 or bit 2 set. `sci` follows the register state one clock later.
- R6: The general-purpose block spans addresses 4 to 7. Status bytes are at 4 and 5; enable bytes are at 6 and 7 and are plain read/write. `evt_pci` sets status byte 0 bit 1 (0x02) and `evt_cpu` sets status byte 0 bit 2 (0x04). Enable bits outside bits 1 and 2 of byte 0 never raise `sci`.
- R7: `evt_tmr` sets the timer status bit only while it is armed, that is while fixed enable bit 0 is 1 and fixed status bit 0 is 0. `tmr_armed` shows that condition.
- R8: Writing 0xF1 to the APM command port (address 10) sets the SCI enable bit, writing 0xF0 clears it, and other values leave it alone. The SCI enable bit reads back as bit 0 of address 8, which software may also write.
- R9: Every write to the APM command port gives a one-cycle `smi` pulse in the next cycle, if bit 1 of the SMI-control byte (address 9, read/write) is set. No pulse is given otherwise.
- R10: Read data appears on `reg_rdata` one clock after `reg_re` and holds until the next read. Address 10 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| evt_tmr | input | 1 | Timer overflow pulse |
| evt_glk | input | 1 | Global lock release pulse |
| evt_pwr | input | 1 | Power button pulse |
| evt_rtc | input | 1 | RTC alarm pulse |
| evt_pci | input | 1 | PCI hotplug pulse |
| evt_cpu | input | 1 | CPU hotplug pulse |
| sci | output | 1 | Level system control interrupt |
| smi | output | 1 | SMI pulse |
| sci_en | output | 1 | SCI enable control bit |
| tmr_armed | output | 1 | Timer overflow event armed |

## Verification
A status bit can be set by a hardware event and cleared by software in the same clock. The bench provokes this by raising the power-button pulse in the same cycle as a write-one-to-clear of that bit, then reads the status back and expects it set. A second overlap comes from the timer: the bench fires overflow pulses while the timer bit is disarmed and while it is already set, and expects the status and `tmr_armed` to stay as the arming rule says. Around every enable or status change the bench samples `sci` both before and after its one-cycle lag.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int PM1_W   = 16;
  localparam int TMR_BIT = 0;
  localparam int GLK_BIT = 5;
  localparam int PWR_BIT = 8;
  localparam int RTC_BIT = 10;
  localparam logic [PM1_W-1:0] PM1_IMPL =
    PM1_W'((1 << TMR_BIT) | (1 << GLK_BIT) | (1 << PWR_BIT) | (1 << RTC_BIT));
  localparam int GPE_PCI_BIT = 1;
  localparam int GPE_CPU_BIT = 2;
  localparam logic [7:0] GPE_SCI_MASK = 8'((1 << GPE_PCI_BIT) | (1 << GPE_CPU_BIT));
  localparam logic [7:0] CMD_SCI_ON  = 8'hF1;
  localparam logic [7:0] CMD_SCI_OFF = 8'hF0;
  localparam int SMI_GATE_BIT = 1;
endpackage

// File: rtl/pm_fixed_regs.sv
module pm_fixed_regs
  import pm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we_sts_lo,
  input  logic             we_sts_hi,
  input  logic             we_en_lo,
  input  logic             we_en_hi,
  input  logic [7:0]       wdata,
  input  logic             evt_tmr,
  input  logic             evt_glk,
  input  logic             evt_pwr,
  input  logic             evt_rtc,
  output logic [PM1_W-1:0] sts,
  output logic [PM1_W-1:0] en
);
  logic [PM1_W-1:0] set_v, clr_v, en_n;

  always_comb begin
    set_v = '0;
    set_v[TMR_BIT] = evt_tmr & en[TMR_BIT] & ~sts[TMR_BIT];
    set_v[GLK_BIT] = evt_glk;
    set_v[PWR_BIT] = evt_pwr;
    set_v[RTC_BIT] = evt_rtc;
    clr_v = {(we_sts_hi ? wdata : 8'h00), (we_sts_lo ? wdata : 8'h00)};
    en_n = en;
    if (we_en_lo) en_n[7:0]  = wdata;
    if (we_en_hi) en_n[15:8] = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= '0;
      en  <= '0;
    end else begin
      sts <= (set_v | (sts & ~clr_v)) & PM1_IMPL;
      en  <= en_n & PM1_IMPL;
    end
  end
endmodule

// File: rtl/pm_gpe_regs.sv
module pm_gpe_regs #(
  parameter int NB    = 2,
  parameter int IDX_W = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IDX_W-1:0] idx,
  input  logic            we_sts,
  input  logic            we_en,
  input  logic [7:0]      wdata,
  input  logic [7:0]      set0,
  output logic [NB*8-1:0] sts_flat,
  output logic [NB*8-1:0] en_flat
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [7:0] sts_q, en_q, set_b, clr_b;
    logic       hit;
    assign hit   = (idx == IDX_W'(b));
    assign set_b = (b == 0) ? set0 : 8'h00;
    assign clr_b = (we_sts && hit) ? wdata : 8'h00;
    always_ff @(posedge clk) begin
      if (rst) begin
        sts_q <= 8'h00;
        en_q  <= 8'h00;
      end else begin
        sts_q <= set_b | (sts_q & ~clr_b);
        if (we_en && hit) en_q <= wdata;
      end
    end
    assign sts_flat[b*8 +: 8] = sts_q;
    assign en_flat[b*8 +: 8]  = en_q;
  end
endmodule

// File: rtl/pm_apm_ctl.sv
module pm_apm_ctl
  import pm_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_we,
  input  logic       ctl_we,
  input  logic       smic_we,
  input  logic [7:0] wdata,
  output logic       sci_en,
  output logic [7:0] smi_ctl,
  output logic       smi
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sci_en  <= 1'b0;
      smi_ctl <= 8'h00;
      smi     <= 1'b0;
    end else begin
      smi <= cmd_we & smi_ctl[SMI_GATE_BIT];
      if (cmd_we) begin
        if (wdata == CMD_SCI_ON)       sci_en <= 1'b1;
        else if (wdata == CMD_SCI_OFF) sci_en <= 1'b0;
      end else if (ctl_we) begin
        sci_en <= wdata[0];
      end
      if (smic_we) smi_ctl <= wdata;
    end
  end
endmodule

// File: rtl/pm_evt_sci.sv
module pm_evt_sci
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int GPE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              evt_tmr,
  input  logic              evt_glk,
  input  logic              evt_pwr,
  input  logic              evt_rtc,
  input  logic              evt_pci,
  input  logic              evt_cpu,
  output logic              sci,
  output logic              smi,
  output logic              sci_en,
  output logic              tmr_armed
);
  localparam int GPE_HALF = GPE_LEN / 2;
  localparam int IDX_W    = (GPE_HALF > 1) ? $clog2(GPE_HALF) : 1;
  localparam logic [ADDR_W-1:0] A_STS_LO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STS_HI = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_EN_LO  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_EN_HI  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_GPE    = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(4 + GPE_LEN);
  localparam logic [ADDR_W-1:0] A_SMIC   = ADDR_W'(5 + GPE_LEN);
  localparam logic [ADDR_W-1:0] A_APM    = ADDR_W'(6 + GPE_LEN);
  localparam logic [ADDR_W-1:0] A_HALF   = ADDR_W'(GPE_HALF);

  logic [PM1_W-1:0]      pm1_sts, pm1_en;
  logic [GPE_HALF*8-1:0] gpe_sts, gpe_en;
  logic [7:0]            smi_ctl, gpe_set0, rd_mux, rdata_q;
  logic [ADDR_W-1:0]     goff;
  logic                  in_gpe, gpe_hi, sci_q;
  logic [IDX_W-1:0]      bidx;

  assign goff   = reg_addr - A_GPE;
  assign in_gpe = (reg_addr >= A_GPE) && (reg_addr < A_CTRL);
  assign gpe_hi = (goff >= A_HALF);
  assign bidx   = IDX_W'(gpe_hi ? (goff - A_HALF) : goff);

  always_comb begin
    gpe_set0 = 8'h00;
    gpe_set0[GPE_PCI_BIT] = evt_pci;
    gpe_set0[GPE_CPU_BIT] = evt_cpu;
  end

  pm_fixed_regs u_fixed (
    .clk(clk), .rst(rst),
    .we_sts_lo(reg_we && reg_addr == A_STS_LO),
    .we_sts_hi(reg_we && reg_addr == A_STS_HI),
    .we_en_lo (reg_we && reg_addr == A_EN_LO),
    .we_en_hi (reg_we && reg_addr == A_EN_HI),
    .wdata(reg_wdata),
    .evt_tmr(evt_tmr), .evt_glk(evt_glk), .evt_pwr(evt_pwr), .evt_rtc(evt_rtc),
    .sts(pm1_sts), .en(pm1_en)
  );

  pm_gpe_regs #(.NB(GPE_HALF), .IDX_W(IDX_W)) u_gpe (
    .clk(clk), .rst(rst), .idx(bidx),
    .we_sts(reg_we && in_gpe && !gpe_hi),
    .we_en (reg_we && in_gpe && gpe_hi),
    .wdata(reg_wdata), .set0(gpe_set0),
    .sts_flat(gpe_sts), .en_flat(gpe_en)
  );

  pm_apm_ctl u_apm (
    .clk(clk), .rst(rst),
    .cmd_we (reg_we && reg_addr == A_APM),
    .ctl_we (reg_we && reg_addr == A_CTRL),
    .smic_we(reg_we && reg_addr == A_SMIC),
    .wdata(reg_wdata),
    .sci_en(sci_en), .smi_ctl(smi_ctl), .smi(smi)
  );

  always_comb begin
    if (reg_addr == A_STS_LO)     rd_mux = pm1_sts[7:0];
    else if (reg_addr == A_STS_HI) rd_mux = pm1_sts[15:8];
    else if (reg_addr == A_EN_LO)  rd_mux = pm1_en[7:0];
    else if (reg_addr == A_EN_HI)  rd_mux = pm1_en[15:8];
    else if (in_gpe)               rd_mux = gpe_hi ? gpe_en[bidx*8 +: 8] : gpe_sts[bidx*8 +: 8];
    else if (reg_addr == A_CTRL)   rd_mux = {7'b0, sci_en};
    else if (reg_addr == A_SMIC)   rd_mux = smi_ctl;
    else                           rd_mux = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= 8'h00;
      sci_q   <= 1'b0;
    end else begin
      if (reg_re) rdata_q <= rd_mux;
      sci_q <= (|(pm1_sts & pm1_en & PM1_IMPL)) |
               (|(gpe_sts[7:0] & gpe_en[7:0] & GPE_SCI_MASK));
    end
  end

  assign reg_rdata = rdata_q;
  assign sci       = sci_q;
  assign tmr_armed = pm1_en[TMR_BIT] & ~pm1_sts[TMR_BIT];
endmodule

// File: rtl/pm_evt_sci_chk.sv
module pm_evt_sci_chk #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] APM_ADDR = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              evt_any,
  input logic              evt_pwr,
  input logic              pwr_sts,
  input logic              smi_gate,
  input logic              sci,
  input logic              smi,
  input logic              sci_en
);
  logic apm_wr;
  assign apm_wr = reg_we && (reg_addr == APM_ADDR);

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!sci && !smi && !sci_en));

  // R4
  evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    evt_pwr |=> pwr_sts);

  // R5
  sci_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sci) |-> $past(evt_any || reg_we, 2));

  // R8
  sci_en_on_chk: assert property (@(posedge clk) disable iff (rst)
    (apm_wr && reg_wdata == 8'hF1) |=> sci_en);

  // R8
  sci_en_off_chk: assert property (@(posedge clk) disable iff (rst)
    (apm_wr && reg_wdata == 8'hF0) |=> !sci_en);

  // R9
  smi_src_chk: assert property (@(posedge clk) disable iff (rst)
    smi |-> $past(apm_wr && smi_gate));

  // R9
  smi_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (apm_wr && smi_gate) |=> smi);
endmodule

bind pm_evt_sci pm_evt_sci_chk #(.ADDR_W(ADDR_W), .APM_ADDR(A_APM)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .evt_any(evt_tmr | evt_glk | evt_pwr | evt_rtc | evt_pci | evt_cpu),
  .evt_pwr(evt_pwr), .pwr_sts(pm1_sts[8]), .smi_gate(smi_ctl[1]),
  .sci(sci), .smi(smi), .sci_en(sci_en)
);

// File: tb/pm_evt_sci_tb.sv
module pm_evt_sci_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic evt_tmr = 0, evt_glk = 0, evt_pwr = 0, evt_rtc = 0, evt_pci = 0, evt_cpu = 0;
  logic sci, smi, sci_en, tmr_armed;
  logic rd_pend = 1'b0;
  int checks = 0, fails = 0;

  typedef struct { string req; logic [7:0] exp; } rd_item_t;
  rd_item_t exp_q[$];

  always #4 clk = ~clk;

  pm_evt_sci u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_tmr(evt_tmr), .evt_glk(evt_glk), .evt_pwr(evt_pwr), .evt_rtc(evt_rtc),
    .evt_pci(evt_pci), .evt_cpu(evt_cpu),
    .sci(sci), .smi(smi), .sci_en(sci_en), .tmr_armed(tmr_armed)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: R10 read data one clock after the strobe
  always @(posedge clk) rd_pend <= reg_re;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() > 0) begin
        rd_item_t it;
        it = exp_q.pop_front();
        chk({it.req, " R10"}, reg_rdata, it.exp);
      end else begin
        chk("R10 unexpected read", 8'h01, 8'h00);
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string req);
    rd_item_t it;
    @(negedge clk);
    it.req = req; it.exp = e;
    exp_q.push_back(it);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // m = {cpu, pci, rtc, pwr, glk, tmr}
  task automatic ev(input logic [5:0] m);
    @(negedge clk);
    {evt_cpu, evt_pci, evt_rtc, evt_pwr, evt_glk, evt_tmr} = m;
    @(negedge clk);
    {evt_cpu, evt_pci, evt_rtc, evt_pwr, evt_glk, evt_tmr} = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 sci", {7'b0, sci}, 8'h00);
    chk("R1 smi", {7'b0, smi}, 8'h00);
    chk("R1 tmr_armed", {7'b0, tmr_armed}, 8'h00);
    for (int a = 0; a < 11; a++) rd(4'(a), 8'h00, "R1 reg");

    // R2 events set fixed status bits
    ev(6'b000100); rd(4'd1, 8'h01, "R2 pwr");
    chk("R5 no enable", {7'b0, sci}, 8'h00);
    ev(6'b001000); rd(4'd1, 8'h05, "R2 rtc");
    ev(6'b000010); rd(4'd0, 8'h20, "R2 glk");
    ev(6'b000001); rd(4'd0, 8'h20, "R7 tmr disarmed");
    chk("R7 armed low", {7'b0, tmr_armed}, 8'h00);

    // R3 write-one-to-clear
    wr(4'd1, 8'h01); rd(4'd1, 8'h04, "R3 clear pwr");
    wr(4'd0, 8'h00); rd(4'd0, 8'h20, "R3 zero write");
    wr(4'd0, 8'h20); rd(4'd0, 8'h00, "R3 clear glk");
    wr(4'd2, 8'hFF); rd(4'd2, 8'h21, "R3 en lo impl");
    wr(4'd2, 8'h00);

    // R5 SCI from rtc, one clock lag
    wr(4'd3, 8'h04);
    chk("R5 lag", {7'b0, sci}, 8'h00);
    tick();
    chk("R5 rtc sci", {7'b0, sci}, 8'h01);
    rd(4'd3, 8'h04, "R3 en hi");
    wr(4'd1, 8'h04);
    chk("R5 hold", {7'b0, sci}, 8'h01);
    tick();
    chk("R5 rtc clr", {7'b0, sci}, 8'h00);
    wr(4'd3, 8'h00);
    ev(6'b000010); wr(4'd2, 8'h20); tick();
    chk("R5 glk sci", {7'b0, sci}, 8'h01);
    wr(4'd0, 8'h20); wr(4'd2, 8'h00); tick();
    chk("R5 glk clr", {7'b0, sci}, 8'h00);

    // R7 timer arming
    wr(4'd2, 8'h01);
    chk("R7 armed", {7'b0, tmr_armed}, 8'h01);
    ev(6'b000001);
    chk("R7 disarm on set", {7'b0, tmr_armed}, 8'h00);
    rd(4'd0, 8'h01, "R7 tmr sts");
    chk("R5 tmr sci", {7'b0, sci}, 8'h01);
    ev(6'b000001); rd(4'd0, 8'h01, "R7 repeat");
    wr(4'd0, 8'h01);
    chk("R7 rearm", {7'b0, tmr_armed}, 8'h01);
    rd(4'd0, 8'h00, "R7 cleared");
    wr(4'd2, 8'h00);
    chk("R7 en off", {7'b0, tmr_armed}, 8'h00);
    chk("R5 tmr off", {7'b0, sci}, 8'h00);

    // R4 event beats same-cycle clear
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd1; reg_wdata = 8'h01; evt_pwr = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; evt_pwr = 1'b0;
    rd(4'd1, 8'h01, "R4 event wins");
    wr(4'd1, 8'h01); rd(4'd1, 8'h00, "R4 later clear");

    // R6 general-purpose block
    ev(6'b010000); rd(4'd4, 8'h02, "R6 pci sts");
    chk("R6 no en", {7'b0, sci}, 8'h00);
    wr(4'd6, 8'h02); tick();
    chk("R6 pci sci", {7'b0, sci}, 8'h01);
    wr(4'd4, 8'h02); tick();
    chk("R6 pci clr", {7'b0, sci}, 8'h00);
    ev(6'b100000); rd(4'd4, 8'h04, "R6 cpu sts");
    chk("R6 cpu masked", {7'b0, sci}, 8'h00);
    wr(4'd6, 8'h05); rd(4'd6, 8'h05, "R6 en rw");
    chk("R6 cpu sci", {7'b0, sci}, 8'h01);
    wr(4'd4, 8'h04); tick();
    chk("R6 cpu clr", {7'b0, sci}, 8'h00);
    wr(4'd7, 8'hA5); rd(4'd7, 8'hA5, "R6 en byte1");
    wr(4'd5, 8'hFF); rd(4'd5, 8'h00, "R6 sts byte1");
    chk("R6 other en", {7'b0, sci}, 8'h00);

    // R8 APM commands
    wr(4'd10, 8'hF1);
    chk("R9 no smi", {7'b0, smi}, 8'h00);
    rd(4'd8, 8'h01, "R8 on");
    wr(4'd10, 8'h55); rd(4'd8, 8'h01, "R8 other");
    wr(4'd10, 8'hF0); rd(4'd8, 8'h00, "R8 off");
    wr(4'd8, 8'h01); rd(4'd8, 8'h01, "R8 sw write");
    wr(4'd8, 8'h00);

    // R9 SMI pulse
    wr(4'd9, 8'h02); rd(4'd9, 8'h02, "R9 ctl");
    wr(4'd10, 8'hF1);
    chk("R9 smi pulse", {7'b0, smi}, 8'h01);
    tick();
    chk("R9 smi end", {7'b0, smi}, 8'h00);
    wr(4'd10, 8'h33);
    chk("R9 any cmd", {7'b0, smi}, 8'h01);
    rd(4'd8, 8'h01, "R8 kept");

    // R10 hold between reads
    rd(4'd10, 8'h00, "R10 cmd port");
    rd(4'd9, 8'h02, "R10 last");
    tick(); tick();
    chk("R10 hold", reg_rdata, 8'h02);

    tick(); tick();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule